// File: doc/BRIEF.md
# Error Record Slot Directory Controller

This block keeps the directory of a persistent error-record store that is divided into fixed 8 KiB slots. The directory is an internal array with one 64-bit record identifier per slot, and an entry's position in the array is the number of the slot that holds the record. An identifier of all zeros or all ones marks the slot as free. The leading slots hold the store header, so their entries never carry a record. The number of header slots follows from the slot count: a header slot has room for 1021 identifiers after its three header words. A store of 1022 or more slots therefore needs a second header slot.

A host controls the block through two 64-bit registers, an argument/result register and a command register. It first writes the argument into the argument register and then writes a command code. Only the command write starts an operation. Commands that need the directory walk through it one entry per cycle while a busy flag is raised. The result is then left in the argument register. Reading that register has no side effects. The record payload, the host bus bridge and the programming of non-volatile memory are handled elsewhere.

Top module: `errdir_ctrl`

## Requirements
- R1: After reset, busy is low, the result register reads 0, the valid-record count is 0 and every directory entry is free.
- R2: While idle, a write to the argument register stores the 64-bit data, and the register keeps that value across any number of cycles without a command.
- R3: Command code 4 (count) places the number of valid entries, zero-extended, in the result register on the next cycle without raising busy.
- R4: Command code 1 (insert) with a new valid identifier stores it in the lowest-numbered free slot above the header slots and returns that slot number. With the default of 16 slots only slot 0 is header, so the first record lands in slot 1. The count rises by one.
- R5: Inserting an identifier that is already present returns its existing slot number and leaves the count unchanged.
- R6: Inserting when no slot is free returns 0xFFFF_FFFF_FFFF_FFFE and changes neither the directory nor the count.
- R7: Command code 2 (lookup) returns the slot number holding the identifier, or all ones when it is absent.
- R8: Command code 3 (clear) writes zero into the matching entry, lowers the count by one and returns the slot number. A freed slot is reused by later inserts in lowest-first order. Clearing an absent identifier returns all ones and changes nothing.
- R9: An argument of all zeros or all ones is never a record: insert returns 0xFFFF_FFFF_FFFF_FFFD, lookup and clear return all ones, and the directory and count are untouched.
- R10: Busy is high from the cycle after a directory command is accepted until its result is in the register. Command writes and argument writes that arrive while busy is high are dropped.
- R11: Command codes other than 1 to 4 are ignored: the result register and the count are unchanged and busy stays low.
- R12: When an argument write and a command write arrive in the same idle cycle, the command uses the argument already held and the new argument data is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| val_we | input | 1 | Write strobe for the argument register |
| val_wdata | input | 64 | Argument write data |
| act_we | input | 1 | Write strobe for the command register |
| act_wdata | input | 64 | Command code |
| value_o | output | 64 | Argument/result register contents |
| busy_o | output | 1 | Directory walk in progress |

## Verification
The hardest situation to reach is a full directory, where every non-header slot holds a distinct valid identifier and the walk must finish without finding either a match or a free entry. The stimulus fills the store one insert at a time. A reference model in the bench tracks which slot each identifier should occupy, including a slot freed earlier and then reused, until the count reaches the usable slot total. A final new identifier must then report the full code. Writes that land during a walk are placed on the cycle right after the command, where busy has just risen, so the drop path is exercised deterministically.

// File: rtl/errdir_pkg.sv
package errdir_pkg;

  localparam int REG_W          = 64;
  localparam int HDR_WORDS      = 3;
  localparam int WORDS_PER_SLOT = 1024;

  localparam logic [REG_W-1:0] CMD_INSERT = 64'd1;
  localparam logic [REG_W-1:0] CMD_LOOKUP = 64'd2;
  localparam logic [REG_W-1:0] CMD_CLEAR  = 64'd3;
  localparam logic [REG_W-1:0] CMD_COUNT  = 64'd4;

  localparam logic [REG_W-1:0] RES_NOT_FOUND = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [REG_W-1:0] RES_FULL      = 64'hFFFF_FFFF_FFFF_FFFE;
  localparam logic [REG_W-1:0] RES_BAD_ID    = 64'hFFFF_FFFF_FFFF_FFFD;

  typedef enum logic [1:0] {OP_NONE, OP_INSERT, OP_LOOKUP, OP_CLEAR} op_e;
  typedef enum logic [1:0] {SC_IDLE, SC_RUN, SC_DONE} scan_st_e;

  // Header slots needed so that the header words plus one id per slot fit.
  function automatic int hdr_slots(input int n);
    return (n + HDR_WORDS + WORDS_PER_SLOT - 1) / WORDS_PER_SLOT;
  endfunction

endpackage

// File: rtl/errdir_store.sv
module errdir_store
  import errdir_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int RSV       = 1,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [REG_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [REG_W-1:0] rd_data
);

  logic [REG_W-1:0] ent_q [NUM_SLOTS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SLOTS; i++) ent_q[i] <= '0;
    end else if (wr_en) begin
      ent_q[wr_idx] <= wr_data;
    end
  end

  assign rd_data = ent_q[rd_idx];

  // R4: header entries must never be written by the controller
  generate
    for (genvar g = 0; g < RSV; g++) begin : g_hdr
      a_r4_hdr_entry_free: assert property (@(posedge clk) disable iff (!rst_n)
        ent_q[g] == '0);
    end
  endgenerate

  a_r4_no_hdr_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_idx) >= RSV));

endmodule

// File: rtl/errdir_scan.sv
module errdir_scan
  import errdir_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int RSV       = 1,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [REG_W-1:0] key,
  output logic [IDX_W-1:0] rd_idx,
  input  logic [REG_W-1:0] rd_data,
  output logic             busy,
  output logic             done,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  output logic             free_ok,
  output logic [IDX_W-1:0] free_idx
);

  localparam logic [IDX_W-1:0] FIRST = IDX_W'(RSV);
  localparam logic [IDX_W-1:0] LAST  = IDX_W'(NUM_SLOTS - 1);

  scan_st_e         st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             hit_q, hit_d;
  logic [IDX_W-1:0] hidx_q, hidx_d;
  logic             fok_q, fok_d;
  logic [IDX_W-1:0] fidx_q, fidx_d;
  logic             ent_free;
  logic             ent_match;

  assign ent_free  = (rd_data == '0) || (&rd_data);
  assign ent_match = (rd_data == key);

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    hit_d  = hit_q;
    hidx_d = hidx_q;
    fok_d  = fok_q;
    fidx_d = fidx_q;
    case (st_q)
      SC_IDLE: begin
        if (start) begin
          st_d  = SC_RUN;
          idx_d = FIRST;
          hit_d = 1'b0;
          fok_d = 1'b0;
        end
      end
      SC_RUN: begin
        if (ent_match) begin
          hit_d  = 1'b1;
          hidx_d = idx_q;
          st_d   = SC_DONE;
        end else begin
          if (ent_free && !fok_q) begin
            fok_d  = 1'b1;
            fidx_d = idx_q;
          end
          if (idx_q == LAST) st_d  = SC_DONE;
          else               idx_d = idx_q + 1'b1;
        end
      end
      SC_DONE: st_d = SC_IDLE;
      default: st_d = SC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SC_IDLE;
      idx_q  <= '0;
      hit_q  <= 1'b0;
      hidx_q <= '0;
      fok_q  <= 1'b0;
      fidx_q <= '0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      hit_q  <= hit_d;
      hidx_q <= hidx_d;
      fok_q  <= fok_d;
      fidx_q <= fidx_d;
    end
  end

  assign rd_idx   = idx_q;
  assign busy     = (st_q != SC_IDLE);
  assign done     = (st_q == SC_DONE);
  assign hit      = hit_q;
  assign hit_idx  = hidx_q;
  assign free_ok  = fok_q;
  assign free_idx = fidx_q;

  // R4: a free slot reported for insertion lies above the header
  a_r4_free_above_hdr: assert property (@(posedge clk) disable iff (!rst_n)
    (done && free_ok) |-> (free_idx >= FIRST));

  // R5: a match is never reported inside the header
  a_r5_hit_above_hdr: assert property (@(posedge clk) disable iff (!rst_n)
    (done && hit) |-> (hit_idx >= FIRST));

  // R10: the walk always ends with one result cycle and then idles
  a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

endmodule

// File: rtl/errdir_ctrl.sv
module errdir_ctrl
  import errdir_pkg::*;
#(
  parameter int NUM_SLOTS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             val_we,
  input  logic [REG_W-1:0] val_wdata,
  input  logic             act_we,
  input  logic [REG_W-1:0] act_wdata,
  output logic [REG_W-1:0] value_o,
  output logic             busy_o
);

  localparam int RSV    = hdr_slots(NUM_SLOTS);
  localparam int USABLE = NUM_SLOTS - RSV;
  localparam int IDX_W  = $clog2(NUM_SLOTS);
  localparam int CNT_W  = $clog2(NUM_SLOTS + 1);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  logic [REG_W-1:0] value_q, value_d;
  logic             value_en;
  logic [CNT_W-1:0] count_q, count_d;
  logic             count_en;
  op_e              op_q, op_d;
  logic             op_en;

  logic             sc_start, sc_busy, sc_done, sc_hit, sc_fok;
  logic [IDX_W-1:0] sc_hidx, sc_fidx, rd_idx;
  logic [REG_W-1:0] rd_data;
  logic             st_we;
  logic [IDX_W-1:0] st_widx;
  logic [REG_W-1:0] st_wdata;

  logic accept;
  logic key_bad;

  assign accept  = act_we && !sc_busy;
  assign key_bad = (value_q == '0) || (&value_q);

  errdir_store #(.NUM_SLOTS(NUM_SLOTS), .RSV(RSV)) u_store (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .wr_en  (st_we),
    .wr_idx (st_widx),
    .wr_data(st_wdata),
    .rd_idx (rd_idx),
    .rd_data(rd_data)
  );

  errdir_scan #(.NUM_SLOTS(NUM_SLOTS), .RSV(RSV)) u_scan (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .start   (sc_start),
    .key     (value_q),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .busy    (sc_busy),
    .done    (sc_done),
    .hit     (sc_hit),
    .hit_idx (sc_hidx),
    .free_ok (sc_fok),
    .free_idx(sc_fidx)
  );

  // Command decode and result commit
  always_comb begin
    value_d  = value_q;
    value_en = 1'b0;
    count_d  = count_q;
    count_en = 1'b0;
    op_d     = op_q;
    op_en    = 1'b0;
    sc_start = 1'b0;
    st_we    = 1'b0;
    st_widx  = sc_hidx;
    st_wdata = '0;

    if (accept) begin
      case (act_wdata)
        CMD_COUNT: begin
          value_d  = REG_W'(count_q);
          value_en = 1'b1;
        end
        CMD_INSERT: begin
          if (key_bad) begin
            value_d  = RES_BAD_ID;
            value_en = 1'b1;
          end else begin
            sc_start = 1'b1;
            op_d     = OP_INSERT;
            op_en    = 1'b1;
          end
        end
        CMD_LOOKUP, CMD_CLEAR: begin
          if (key_bad) begin
            value_d  = RES_NOT_FOUND;
            value_en = 1'b1;
          end else begin
            sc_start = 1'b1;
            op_d     = (act_wdata == CMD_LOOKUP) ? OP_LOOKUP : OP_CLEAR;
            op_en    = 1'b1;
          end
        end
        default: ;
      endcase
    end else if (val_we && !sc_busy) begin
      value_d  = val_wdata;
      value_en = 1'b1;
    end

    if (sc_done) begin
      value_en = 1'b1;
      case (op_q)
        OP_INSERT: begin
          if (sc_hit) begin
            value_d = REG_W'(sc_hidx);
          end else if (sc_fok) begin
            st_we    = 1'b1;
            st_widx  = sc_fidx;
            st_wdata = value_q;
            count_d  = count_q + 1'b1;
            count_en = 1'b1;
            value_d  = REG_W'(sc_fidx);
          end else begin
            value_d = RES_FULL;
          end
        end
        OP_LOOKUP: value_d = sc_hit ? REG_W'(sc_hidx) : RES_NOT_FOUND;
        OP_CLEAR: begin
          if (sc_hit) begin
            st_we    = 1'b1;
            st_widx  = sc_hidx;
            st_wdata = '0;
            count_d  = count_q - 1'b1;
            count_en = 1'b1;
            value_d  = REG_W'(sc_hidx);
          end else begin
            value_d = RES_NOT_FOUND;
          end
        end
        default: value_en = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      value_q <= '0;
      count_q <= '0;
      op_q    <= OP_NONE;
    end else begin
      if (value_en) value_q <= value_d;
      if (count_en) count_q <= count_d;
      if (op_en)    op_q    <= op_d;
    end
  end

  assign value_o = value_q;
  assign busy_o  = sc_busy;

  // R3: the count never exceeds the number of record slots
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n_s)
    int'(count_q) <= USABLE);

  // R8: the count moves only when a walk commits its result
  a_r8_count_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n_s)
    !sc_done |=> $stable(count_q));

  // R10: the register is frozen while a walk runs
  a_r10_value_frozen: assert property (@(posedge clk) disable iff (!rst_n_s)
    (sc_busy && !sc_done) |=> $stable(value_q));

  // R9: an invalid argument never starts a walk
  a_r9_bad_key_no_walk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (accept && key_bad) |=> !sc_busy);

  // R11: unknown command codes leave everything untouched
  a_r11_unknown_ignored: assert property (@(posedge clk) disable iff (!rst_n_s)
    (accept && (act_wdata == '0 || act_wdata > CMD_COUNT))
      |=> ($stable(value_q) && $stable(count_q) && !sc_busy));

endmodule

// File: tb/errdir_ctrl_tb_top.sv
module errdir_ctrl_tb_top;
  import errdir_pkg::*;

  localparam int N   = 16;
  localparam int RSV = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        val_we = 1'b0;
  logic [63:0] val_wdata = '0;
  logic        act_we = 1'b0;
  logic [63:0] act_wdata = '0;
  logic [63:0] value_o;
  logic        busy_o;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  logic [63:0] mdl [N];
  int          mcnt = 0;

  always #4 clk = ~clk;

  errdir_ctrl #(.NUM_SLOTS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .val_we(val_we), .val_wdata(val_wdata),
    .act_we(act_we), .act_wdata(act_wdata), .value_o(value_o), .busy_o(busy_o)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic setv(input logic [63:0] x);
    @(negedge clk); val_we = 1'b1; val_wdata = x;
    @(negedge clk); val_we = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
  endtask

  task automatic cmd(input logic [63:0] code);
    @(negedge clk); act_we = 1'b1; act_wdata = code;
    @(negedge clk); act_we = 1'b0;
    wait_idle();
  endtask

  function automatic bit id_bad(input logic [63:0] id);
    return (id == '0) || (&id);
  endfunction

  function automatic int m_find(input logic [63:0] id);
    for (int i = RSV; i < N; i++) if (!id_bad(id) && mdl[i] == id) return i;
    return -1;
  endfunction

  // Model of insert: returns expected result and updates model
  function automatic logic [63:0] m_insert(input logic [63:0] id);
    int h;
    if (id_bad(id)) return RES_BAD_ID;
    h = m_find(id);
    if (h >= 0) return 64'(h);
    for (int i = RSV; i < N; i++) begin
      if (id_bad(mdl[i])) begin
        mdl[i] = id; mcnt++; return 64'(i);
      end
    end
    return RES_FULL;
  endfunction

  function automatic logic [63:0] m_clear(input logic [63:0] id);
    int h;
    h = m_find(id);
    if (h < 0) return RES_NOT_FOUND;
    mdl[h] = '0; mcnt--; return 64'(h);
  endfunction

  function automatic logic [63:0] m_lookup(input logic [63:0] id);
    int h;
    h = m_find(id);
    return (h < 0) ? RES_NOT_FOUND : 64'(h);
  endfunction

  task automatic do_insert(input string req, input logic [63:0] id);
    logic [63:0] e;
    e = m_insert(id);
    setv(id); cmd(CMD_INSERT);
    check(req, value_o, e);
  endtask

  task automatic do_lookup(input string req, input logic [63:0] id);
    setv(id); cmd(CMD_LOOKUP);
    check(req, value_o, m_lookup(id));
  endtask

  task automatic do_clear(input string req, input logic [63:0] id);
    logic [63:0] e;
    e = m_clear(id);
    setv(id); cmd(CMD_CLEAR);
    check(req, value_o, e);
  endtask

  task automatic do_count(input string req);
    cmd(CMD_COUNT);
    check(req, value_o, 64'(mcnt));
  endtask

  task automatic t_reset();
    check("R1 value after reset", value_o, 64'd0);
    check("R1 busy after reset", 64'(busy_o), 64'd0);
    do_count("R1 R3 count after reset");
    do_lookup("R1 R7 lookup in empty store", 64'h1234);
  endtask

  task automatic t_value_reg();
    setv(64'hDEAD_BEEF_0123_4567);
    check("R2 stored value", value_o, 64'hDEAD_BEEF_0123_4567);
    repeat (3) @(negedge clk);
    check("R2 value held without side effect", value_o, 64'hDEAD_BEEF_0123_4567);
  endtask

  task automatic t_insert();
    do_insert("R4 first insert lands at slot 1", 64'hA0A0);
    do_insert("R4 second insert", 64'hB0B0);
    do_insert("R4 third insert", 64'hC0C0);
    do_count("R3 R4 count after inserts");
  endtask

  task automatic t_dup();
    do_insert("R5 duplicate returns same slot", 64'hB0B0);
    do_count("R5 count unchanged by duplicate");
  endtask

  task automatic t_lookup();
    do_lookup("R7 lookup present id", 64'hC0C0);
    do_lookup("R7 lookup absent id", 64'hD0D0);
  endtask

  task automatic t_clear();
    do_clear("R8 clear present id", 64'hA0A0);
    do_count("R8 count after clear");
    do_clear("R8 clear absent id", 64'hA0A0);
    do_insert("R8 freed slot reused lowest first", 64'hD0D0);
    do_count("R8 count after reuse");
  endtask

  task automatic t_bad_id();
    do_insert("R9 insert all zeros", 64'h0);
    do_insert("R9 insert all ones", '1);
    do_lookup("R9 lookup all zeros", 64'h0);
    do_clear("R9 clear all ones", '1);
    do_count("R9 count untouched");
  endtask

  task automatic t_busy();
    logic [63:0] e;
    e = m_insert(64'hE0E0);
    setv(64'hE0E0);
    @(negedge clk); act_we = 1'b1; act_wdata = CMD_INSERT;
    @(negedge clk);
    check("R10 busy after accepted insert", 64'(busy_o), 64'd1);
    act_wdata = CMD_COUNT; val_we = 1'b1; val_wdata = 64'h99;
    @(negedge clk); act_we = 1'b0; val_we = 1'b0;
    wait_idle();
    check("R10 writes during walk dropped", value_o, e);
    do_count("R10 only one insert took effect");
  endtask

  task automatic t_unknown();
    setv(64'h5555);
    cmd(64'd0);
    check("R11 code 0 ignored", value_o, 64'h5555);
    cmd(64'd7);
    check("R11 code 7 ignored", value_o, 64'h5555);
    check("R11 no busy", 64'(busy_o), 64'd0);
    do_count("R11 count unchanged");
  endtask

  task automatic t_same_cycle();
    logic [63:0] e;
    e = m_insert(64'hF0F0);
    setv(64'hF0F0);
    @(negedge clk); act_we = 1'b1; act_wdata = CMD_INSERT; val_we = 1'b1; val_wdata = 64'h6060;
    @(negedge clk); act_we = 1'b0; val_we = 1'b0;
    wait_idle();
    check("R12 command used held argument", value_o, e);
    do_lookup("R12 dropped argument not stored", 64'h6060);
  endtask

  task automatic t_full();
    int k;
    k = 0;
    while (mcnt < N - RSV) begin
      do_insert("R4 fill insert", 64'h1000 + 64'(k));
      k++;
    end
    do_count("R3 count at full");
    do_insert("R6 insert into full store", 64'h7777);
    do_count("R6 count unchanged when full");
    do_lookup("R6 full-store id absent", 64'h7777);
    do_lookup("R7 lookup last slot", 64'h1000 + 64'(k - 1));
  endtask

  initial begin
    for (int i = 0; i < N; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_value_reg();
    t_insert();
    t_dup();
    t_lookup();
    t_clear();
    t_bad_id();
    t_busy();
    t_unknown();
    t_same_cycle();
    t_full();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got hung expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule